// File: doc/BRIEF.md
# Half-to-Single Precision Widening Converter

This block widens a 16-bit IEEE-754 half-precision operand into the 32-bit single-precision value that stands for the same number. Single precision has a wider range and a longer fraction than half precision, so every half value has an exact single-precision form and no rounding is needed. Half-precision subnormals become single-precision normals: a leading-zero count of the fraction gives the shift that moves the leading one into the hidden-bit position. Signed zeros and infinities pass through with their sign. NaN payloads are kept, left-aligned in the wider fraction.

A mode input chooses how NaNs are handled. With the mode low, a NaN keeps its sign and payload and its quiet bit is forced to 1. With the mode high, every NaN becomes one fixed canonical quiet NaN. A separate flag marks signalling-NaN operands in both modes. The result and the flag are registered, so they appear one clock after the operand is presented.

Top module: `half_to_single_widen`

## Requirements
- R1: For a normal input (exponent field 1..30), the output has the same sign in bit 31. Output bits 30:23 hold the input exponent plus 112. Output bits 22:13 hold the input fraction, and bits 12:0 are zero. Input fields are: sign in bit 15, exponent in bits 14:10, fraction in bits 9:0.
- R2: An input with exponent 0 and fraction 0 gives a zero with the input sign: 0x00000000 or 0x80000000.
- R3: An input with exponent 31 and fraction 0 gives 0x7F800000 when the sign is clear and 0xFF800000 when it is set.
- R4: For a subnormal input (exponent 0, fraction not 0), let p be the position of the highest set bit of the fraction. The output exponent is 103 + p. The fraction bits below p, shifted left by 23 - p, form the 23-bit output fraction. The sign is kept.
- R5: With `dflt_nan_i` low, a NaN input (exponent 31, fraction not 0) gives sign, exponent 0xFF, bit 22 forced to 1, bits 21:13 equal to input fraction bits 8:0, and bits 12:0 zero.
- R6: With `dflt_nan_i` high, every NaN input gives exactly 0x7FC00000, whatever its sign and payload.
- R7: `nv_flag_o` is 1 for a signalling NaN (exponent 31, fraction not 0, fraction bit 9 clear), in both modes.
- R8: `nv_flag_o` is 0 for every non-NaN input and for every quiet NaN input (fraction bit 9 set).
- R9: While `rst` is high, both outputs are 0 at the next clock edge. Otherwise the outputs show the result for the inputs sampled at the previous rising edge, so the latency is exactly one cycle.
- R10: `dflt_nan_i` does not change the result or the flag for a non-NaN input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dflt_nan_i | input | 1 | 1 selects canonical-NaN output, 0 keeps NaN payloads |
| half_i | input | 16 | Half-precision operand |
| single_o | output | 32 | Single-precision result, registered |
| nv_flag_o | output | 1 | Invalid-operation flag for signalling-NaN operands, registered |

## Verification
The bench uses the default parameters: a 5-bit exponent with a 10-bit fraction in, and an 8-bit exponent with a 23-bit fraction out. With these widths the whole input space is only 65536 codes per mode. Every code is applied in both NaN modes and checked bit-exactly against an expected value that the bench builds from sign, exponent and fraction arithmetic. This reaches every subnormal shift amount, both zero and infinity signs, all quiet and signalling payloads, and the exponent edges 1 and 30 with no sampling gaps.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

  typedef enum logic [2:0] {
    KIND_ZERO = 3'd0,
    KIND_SUB  = 3'd1,
    KIND_NORM = 3'd2,
    KIND_INF  = 3'd3,
    KIND_QNAN = 3'd4,
    KIND_SNAN = 3'd5
  } fp_kind_e;

  function automatic logic kind_is_nan(input fp_kind_e k);
    return (k == KIND_QNAN) || (k == KIND_SNAN);
  endfunction

endpackage

// File: rtl/hsw_classify.sv
module hsw_classify
  import hsw_pkg::*;
#(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  output fp_kind_e          kind_o
);

  localparam logic [EXP_W-1:0] EXP_TOP = {EXP_W{1'b1}};

  logic exp_min;
  logic exp_max;
  logic frac_nz;
  logic quiet_bit;

  assign exp_min   = (exp_i == '0);
  assign exp_max   = (exp_i == EXP_TOP);
  assign frac_nz   = |frac_i;
  assign quiet_bit = frac_i[FRAC_W-1];

  always_comb begin
    kind_o = KIND_NORM;
    if (exp_min) begin
      kind_o = frac_nz ? KIND_SUB : KIND_ZERO;
    end else if (exp_max) begin
      if (!frac_nz)       kind_o = KIND_INF;
      else if (quiet_bit) kind_o = KIND_QNAN;
      else                kind_o = KIND_SNAN;
    end
  end

endmodule

// File: rtl/hsw_lzc.sv
module hsw_lzc #(
  parameter int W   = 10,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             all_zero_o
);

  logic [CNT_W-1:0] pos_cnt [W];

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_pos
      assign pos_cnt[g] = CNT_W'(W - 1 - g);
    end
  endgenerate

  always_comb begin
    cnt_o = CNT_W'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) cnt_o = pos_cnt[i];
    end
  end

  assign all_zero_o = ~|vec_i;

endmodule

// File: rtl/hsw_assemble.sv
module hsw_assemble
  import hsw_pkg::*;
#(
  parameter int IN_EXP_W   = 5,
  parameter int IN_FRAC_W  = 10,
  parameter int OUT_EXP_W  = 8,
  parameter int OUT_FRAC_W = 23,
  parameter int LZ_W       = $clog2(IN_FRAC_W + 1),
  parameter int OUT_W      = 1 + OUT_EXP_W + OUT_FRAC_W
) (
  input  fp_kind_e               kind_i,
  input  logic                   sign_i,
  input  logic [IN_EXP_W-1:0]    exp_i,
  input  logic [IN_FRAC_W-1:0]   frac_i,
  input  logic [LZ_W-1:0]        lz_i,
  input  logic                   dflt_nan_i,
  output logic [OUT_W-1:0]       word_o,
  output logic                   nv_o
);

  localparam int IN_BIAS  = (1 << (IN_EXP_W - 1)) - 1;
  localparam int OUT_BIAS = (1 << (OUT_EXP_W - 1)) - 1;
  localparam int FR_SH    = OUT_FRAC_W - IN_FRAC_W;
  localparam logic [OUT_EXP_W-1:0] REBIAS  = OUT_EXP_W'(OUT_BIAS - IN_BIAS);
  localparam logic [OUT_EXP_W-1:0] EXP_ALL = {OUT_EXP_W{1'b1}};
  localparam logic [OUT_W-1:0] CANON_NAN =
    {1'b0, EXP_ALL, 1'b1, {(OUT_FRAC_W-1){1'b0}}};

  logic [IN_FRAC_W-1:0]  sub_aligned;
  logic [OUT_FRAC_W-1:0] frac_norm;
  logic [OUT_FRAC_W-1:0] frac_sub;
  logic [OUT_FRAC_W-1:0] frac_nan;
  logic [OUT_EXP_W-1:0]  exp_norm;
  logic [OUT_EXP_W-1:0]  exp_sub;

  assign sub_aligned = frac_i << (lz_i + 1'b1);
  assign frac_norm   = {frac_i, {FR_SH{1'b0}}};
  assign frac_sub    = {sub_aligned, {FR_SH{1'b0}}};
  assign frac_nan    = {1'b1, frac_i[IN_FRAC_W-2:0], {FR_SH{1'b0}}};
  assign exp_norm    = OUT_EXP_W'(exp_i) + REBIAS;
  assign exp_sub     = REBIAS - OUT_EXP_W'(lz_i);

  always_comb begin
    word_o = '0;
    nv_o   = 1'b0;
    unique case (kind_i)
      KIND_ZERO: word_o = {sign_i, {(OUT_W-1){1'b0}}};
      KIND_SUB:  word_o = {sign_i, exp_sub, frac_sub};
      KIND_NORM: word_o = {sign_i, exp_norm, frac_norm};
      KIND_INF:  word_o = {sign_i, EXP_ALL, {OUT_FRAC_W{1'b0}}};
      KIND_QNAN, KIND_SNAN: begin
        word_o = dflt_nan_i ? CANON_NAN : {sign_i, EXP_ALL, frac_nan};
        nv_o   = (kind_i == KIND_SNAN);
      end
      default: word_o = '0;
    endcase
  end

endmodule

// File: rtl/half_to_single_widen.sv
module half_to_single_widen
  import hsw_pkg::*;
#(
  parameter int IN_EXP_W   = 5,
  parameter int IN_FRAC_W  = 10,
  parameter int OUT_EXP_W  = 8,
  parameter int OUT_FRAC_W = 23,
  parameter int IN_W       = 1 + IN_EXP_W + IN_FRAC_W,
  parameter int OUT_W      = 1 + OUT_EXP_W + OUT_FRAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dflt_nan_i,
  input  logic [IN_W-1:0]  half_i,
  output logic [OUT_W-1:0] single_o,
  output logic             nv_flag_o
);

  localparam int LZ_W = $clog2(IN_FRAC_W + 1);
  localparam logic [IN_EXP_W-1:0]  IN_EXP_ALL  = {IN_EXP_W{1'b1}};
  localparam logic [OUT_EXP_W-1:0] OUT_EXP_ALL = {OUT_EXP_W{1'b1}};
  localparam logic [OUT_W-1:0] CANON_NAN_CHK =
    {1'b0, OUT_EXP_ALL, 1'b1, {(OUT_FRAC_W-1){1'b0}}};

  logic                 in_sign;
  logic [IN_EXP_W-1:0]  in_exp;
  logic [IN_FRAC_W-1:0] in_frac;
  fp_kind_e             kind;
  logic [LZ_W-1:0]      lz;
  logic                 lz_zero;
  logic [OUT_W-1:0]     word_c;
  logic                 nv_c;

  assign in_sign = half_i[IN_W-1];
  assign in_exp  = half_i[IN_W-2 -: IN_EXP_W];
  assign in_frac = half_i[IN_FRAC_W-1:0];

  hsw_classify #(
    .EXP_W  (IN_EXP_W),
    .FRAC_W (IN_FRAC_W)
  ) u_cls (
    .exp_i  (in_exp),
    .frac_i (in_frac),
    .kind_o (kind)
  );

  hsw_lzc #(
    .W     (IN_FRAC_W),
    .CNT_W (LZ_W)
  ) u_lzc (
    .vec_i      (in_frac),
    .cnt_o      (lz),
    .all_zero_o (lz_zero)
  );

  hsw_assemble #(
    .IN_EXP_W   (IN_EXP_W),
    .IN_FRAC_W  (IN_FRAC_W),
    .OUT_EXP_W  (OUT_EXP_W),
    .OUT_FRAC_W (OUT_FRAC_W),
    .LZ_W       (LZ_W),
    .OUT_W      (OUT_W)
  ) u_asm (
    .kind_i     (kind),
    .sign_i     (in_sign),
    .exp_i      (in_exp),
    .frac_i     (in_frac),
    .lz_i       (lz),
    .dflt_nan_i (dflt_nan_i),
    .word_o     (word_c),
    .nv_o       (nv_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      single_o  <= '0;
      nv_flag_o <= 1'b0;
    end else begin
      single_o  <= word_c;
      nv_flag_o <= nv_c;
    end
  end

  // R4: a subnormal never reaches the assembler with an empty fraction
  always_comb begin
    if (!rst && kind == KIND_SUB) begin
      sub_nonempty_chk: assert (!lz_zero);
    end
  end

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (single_o == '0 && !nv_flag_o));

  // R7
  snan_flag_chk: assert property (@(posedge clk) disable iff (rst || $past(rst))
    $past(half_i[IN_W-2 -: IN_EXP_W] == IN_EXP_ALL && half_i[IN_FRAC_W-1:0] != '0
          && !half_i[IN_FRAC_W-1]) |-> nv_flag_o);

  // R8
  flag_quiet_chk: assert property (@(posedge clk) disable iff (rst || $past(rst))
    $past(half_i[IN_W-2 -: IN_EXP_W] != IN_EXP_ALL || half_i[IN_FRAC_W-1])
    |-> !nv_flag_o);

  // R6
  canon_nan_chk: assert property (@(posedge clk) disable iff (rst || $past(rst))
    $past(dflt_nan_i && half_i[IN_W-2 -: IN_EXP_W] == IN_EXP_ALL
          && half_i[IN_FRAC_W-1:0] != '0) |-> (single_o == CANON_NAN_CHK));

  // R5
  quiet_out_chk: assert property (@(posedge clk) disable iff (rst || $past(rst))
    $past(half_i[IN_W-2 -: IN_EXP_W] == IN_EXP_ALL && half_i[IN_FRAC_W-1:0] != '0)
    |-> (single_o[OUT_W-2 -: OUT_EXP_W] == OUT_EXP_ALL && single_o[OUT_FRAC_W-1]));

  // R2
  zero_keep_chk: assert property (@(posedge clk) disable iff (rst || $past(rst))
    $past(half_i[IN_W-2:0] == '0)
    |-> (single_o[OUT_W-2:0] == '0 && single_o[OUT_W-1] == $past(half_i[IN_W-1])));

  // R3
  inf_out_chk: assert property (@(posedge clk) disable iff (rst || $past(rst))
    $past(half_i[IN_W-2 -: IN_EXP_W] == IN_EXP_ALL && half_i[IN_FRAC_W-1:0] == '0)
    |-> (single_o == {$past(half_i[IN_W-1]), OUT_EXP_ALL, {OUT_FRAC_W{1'b0}}}));

endmodule

// File: tb/half_to_single_widen_tb_top.sv
`timescale 1ns/1ps
module half_to_single_widen_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dn  = 1'b0;
  logic [15:0] hin = '0;
  logic [31:0] sout;
  logic        nv;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  half_to_single_widen dut_i (
    .clk        (clk),
    .rst        (rst),
    .dflt_nan_i (dn),
    .half_i     (hin),
    .single_o   (sout),
    .nv_flag_o  (nv)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv,
                       input logic fa, input logic fe, input logic [15:0] code, input logic m);
    total++;
    if (act !== expv || fa !== fe) begin
      bad++;
      $display("FAIL %s in=%h dn=%0d act=%h/%0d exp=%h/%0d", tag, code, m, act, fa, expv, fe);
    end
  endtask

  task automatic model(input logic [15:0] h, input logic m,
                       output logic [31:0] r, output logic f, output string tag);
    logic       s;
    int         e;
    int         fr;
    int         p;
    int         rest;
    s = h[15]; e = int'(h[14:10]); fr = int'(h[9:0]); f = 1'b0;
    if (e == 0 && fr == 0) begin
      r = {s, 31'd0}; tag = "R2";
    end else if (e == 31 && fr == 0) begin
      r = s ? 32'hFF800000 : 32'h7F800000; tag = "R3";
    end else if (e == 31) begin
      f = ~h[9];
      r = m ? 32'h7FC00000 : {s, 8'hFF, 1'b1, h[8:0], 13'd0};
      tag = m ? (f ? "R6/R7" : "R6/R8") : (f ? "R5/R7" : "R5/R8");
    end else if (e == 0) begin
      p = 0;
      for (int i = 0; i < 10; i++) if (fr[i]) p = i;
      rest = fr - (1 << p);
      r = {s, 8'(103 + p), 23'(rest << (23 - p))};
      tag = m ? "R4/R10" : "R4";
    end else begin
      r = {s, 8'(e + 112), h[9:0], 13'd0};
      tag = m ? "R1/R10" : "R1";
    end
  endtask

  initial begin
    logic [31:0] er;
    logic        ef;
    string       tg;
    hin = 16'h3C00;
    repeat (3) @(negedge clk);
    check("R9 reset", sout, 32'd0, nv, 1'b0, hin, dn);
    hin = 16'h7D00;
    @(negedge clk);
    check("R9 reset sNaN", sout, 32'd0, nv, 1'b0, hin, dn);
    rst = 1'b0;
    for (int md = 0; md < 2; md++) begin
      dn = md[0];
      for (int c = 0; c < 65536; c++) begin
        hin = 16'(c);
        @(negedge clk);
        model(hin, dn, er, ef, tg);
        check(tg, sout, er, nv, ef, hin, dn);
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule